// File: doc/BRIEF.md
# Readout Throttle Controller

This block decides when data flow through a pixel-detector readout chain has to be held back. It watches three independent causes: the fill level of the local readout FIFO, flow-control pause requests that a receive parser has already decoded from incoming Ethernet frames, and a front-end disable line driven by neighbouring detectors. From these it drives a front-end veto, a transmit-hold signal for the packet sender and a gated shutter. It also issues single-cycle requests that let a packet formatter send a "busy" notice to the host when throttling starts and a "continue" notice when it ends.

The FIFO cause uses two level flags: it engages on the almost-full flag and clears only when a separate low-water flag is seen, so the veto cannot chatter around a single threshold. A pause request loads a down-counter with the requested number of quanta, each worth 512 bit times and counted in transmit-clock cycles at a parameterised datapath width. The external disable passes through a synchronizer before use. Only the front-end causes (FIFO, external) raise the front-end veto. A host pause holds only the transmitter, but it still counts towards the busy notice and the shutter gate.

Top module: `rdo_throttle`

## Requirements
- R1: While reset is high and in the first cycle after it falls, fe_veto_o, tx_pause_o, busy_req_o, cont_req_o and shutter_o are all 0.
- R2: An almost-full flag that is high at a clock edge makes fe_veto_o 1 after that edge.
- R3: Once set by almost-full, the FIFO throttle holds fe_veto_o at 1 until the low-water flag is seen with almost-full low. If both flags are high together, almost-full wins and the throttle stays set.
- R4: ext_fe_dis_i reaches fe_veto_o through EXT_STAGES registers (2 by default), both when it rises and when it falls.
- R5: A pause request with quanta Q>0 holds tx_pause_o at 1 for exactly Q*512/BITS_PER_CYC cycles, starting the cycle after the request (24 cycles for Q=3 at 64 bits per cycle).
- R6: A new pause request reloads the counter at once: a request with Q=0 releases tx_pause_o after the next edge, and a request with Q>0 restarts the full count.
- R7: A pause request never asserts fe_veto_o.
- R8: busy_req_o pulses for exactly one cycle, one cycle after the combined busy condition (FIFO throttle or synchronized external disable or active pause) goes from 0 to 1.
- R9: cont_req_o pulses for exactly one cycle, one cycle after the combined busy condition goes from 1 to 0. Overlapping causes produce a single busy/continue pair, and the two pulses never occur in the same cycle.
- R10: shutter_o is a registered copy of shutter_i while no cause is active, and is 0 in every cycle that follows a cycle with the busy condition set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_afull_i | input | 1 | Readout FIFO almost-full flag |
| fifo_alow_i | input | 1 | Readout FIFO low-water flag |
| pause_valid_i | input | 1 | One-cycle strobe: a pause request was decoded |
| pause_quanta_i | input | QUANTA_W | Requested pause length in quanta |
| ext_fe_dis_i | input | 1 | Front-end disable from other detectors (asynchronous) |
| shutter_i | input | 1 | Requested shutter state |
| fe_veto_o | output | 1 | Front-end disable/veto |
| tx_pause_o | output | 1 | Hold for the transmit packet sender |
| busy_req_o | output | 1 | One-cycle request to emit a busy notice |
| cont_req_o | output | 1 | One-cycle request to emit a continue notice |
| shutter_o | output | 1 | Gated shutter |

## Verification
The main function is tried with each cause on its own: the FIFO flags in set/hold/clear order and with both flags high together, the external disable, and pause requests of several lengths. Each run shows that only the right output reacts, and that the latency differs between the synchronized external path and the FIFO path. Pause requests that are cut short with a zero request, or extended by a second request, tell a reloading counter apart from one that adds or ignores new requests. A run where the FIFO and external causes overlap tells an OR-merged busy condition apart from per-cause notification, because it must give exactly one busy/continue pair. The scoreboard compares the order of all notification pulses against expectations queued by the driver.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int unsigned QUANTUM_BITS = 512;

  typedef struct packed {
    logic fifo;
    logic ext;
    logic pause;
  } thr_cause_t;

  function automatic int unsigned quantum_cycles(input int unsigned bits_per_cyc);
    return QUANTUM_BITS / bits_per_cyc;
  endfunction

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/thr_level_hyst.sv
module thr_level_hyst (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic thr_o
);
  // set dominates clear; otherwise hold
  always_ff @(posedge clk) begin
    if (rst)        thr_o <= 1'b0;
    else if (set_i) thr_o <= 1'b1;
    else if (clr_i) thr_o <= 1'b0;
  end
endmodule

// File: rtl/thr_pause_timer.sv
module thr_pause_timer #(
  parameter int unsigned QUANTA_W     = 16,
  parameter int unsigned BITS_PER_CYC = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [QUANTA_W-1:0] quanta_i,
  output logic                active_o
);
  import thr_pkg::*;
  localparam int unsigned CYC_PER_Q = quantum_cycles(BITS_PER_CYC);
  localparam int unsigned SHIFT     = $clog2(CYC_PER_Q);
  localparam int unsigned CNT_W     = QUANTA_W + SHIFT + 1;

  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (is_pow2(CYC_PER_Q)) begin : g_shift
      assign load_val = CNT_W'(quanta_i) << SHIFT;
    end else begin : g_mult
      assign load_val = CNT_W'(quanta_i) * CNT_W'(CYC_PER_Q);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/thr_notify.sv
module thr_notify (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  input  logic shutter_i,
  output logic busy_req_o,
  output logic cont_req_o,
  output logic shutter_o
);
  logic busy_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_prev_q <= 1'b0;
      busy_req_o  <= 1'b0;
      cont_req_o  <= 1'b0;
      shutter_o   <= 1'b0;
    end else begin
      busy_prev_q <= busy_i;
      busy_req_o  <= busy_i & ~busy_prev_q;
      cont_req_o  <= ~busy_i & busy_prev_q;
      shutter_o   <= shutter_i & ~busy_i;
    end
  end
endmodule

// File: rtl/rdo_throttle.sv
module rdo_throttle #(
  parameter int unsigned QUANTA_W     = 16,
  parameter int unsigned BITS_PER_CYC = 64,
  parameter int unsigned EXT_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fifo_afull_i,
  input  logic                fifo_alow_i,
  input  logic                pause_valid_i,
  input  logic [QUANTA_W-1:0] pause_quanta_i,
  input  logic                ext_fe_dis_i,
  input  logic                shutter_i,
  output logic                fe_veto_o,
  output logic                tx_pause_o,
  output logic                busy_req_o,
  output logic                cont_req_o,
  output logic                shutter_o
);
  import thr_pkg::*;

  thr_cause_t            cause;
  logic                  fifo_thr;
  logic [EXT_STAGES-1:0] ext_sr;
  logic                  busy_now;

  thr_level_hyst u_hyst (
    .clk   (clk),
    .rst   (rst),
    .set_i (fifo_afull_i),
    .clr_i (fifo_alow_i),
    .thr_o (fifo_thr)
  );

  generate
    if (EXT_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) ext_sr <= '0;
        else     ext_sr <= ext_fe_dis_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) ext_sr <= '0;
        else     ext_sr <= {ext_sr[EXT_STAGES-2:0], ext_fe_dis_i};
      end
    end
  endgenerate

  thr_pause_timer #(
    .QUANTA_W     (QUANTA_W),
    .BITS_PER_CYC (BITS_PER_CYC)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load_i   (pause_valid_i),
    .quanta_i (pause_quanta_i),
    .active_o (cause.pause)
  );

  assign cause.fifo = fifo_thr;
  assign cause.ext  = ext_sr[EXT_STAGES-1];
  assign busy_now   = |cause;
  assign fe_veto_o  = cause.fifo | cause.ext;
  assign tx_pause_o = cause.pause;

  thr_notify u_notify (
    .clk        (clk),
    .rst        (rst),
    .busy_i     (busy_now),
    .shutter_i  (shutter_i),
    .busy_req_o (busy_req_o),
    .cont_req_o (cont_req_o),
    .shutter_o  (shutter_o)
  );
endmodule

// File: rtl/rdo_throttle_chk.sv
module rdo_throttle_chk #(
  parameter int unsigned QUANTA_W   = 16,
  parameter int unsigned EXT_STAGES = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                fifo_afull_i,
  input logic                fifo_alow_i,
  input logic                pause_valid_i,
  input logic [QUANTA_W-1:0] pause_quanta_i,
  input logic                ext_fe_dis_i,
  input logic                fe_veto_o,
  input logic                tx_pause_o,
  input logic                busy_req_o,
  input logic                cont_req_o,
  input logic                shutter_o,
  input logic                fifo_thr
);
  a_r2_afull_vetoes: assert property (@(posedge clk) disable iff (rst)
    fifo_afull_i |=> fe_veto_o);

  a_r3_hyst_holds: assert property (@(posedge clk) disable iff (rst)
    (fifo_thr && !fifo_alow_i) |=> fifo_thr);

  generate
    if (EXT_STAGES <= 2) begin : g_r4
      a_r4_ext_vetoes: assert property (@(posedge clk) disable iff (rst)
        (ext_fe_dis_i && $past(ext_fe_dis_i)) |=> fe_veto_o);
    end
  endgenerate

  a_r5_pause_starts: assert property (@(posedge clk) disable iff (rst)
    (pause_valid_i && pause_quanta_i != '0) |=> tx_pause_o);

  a_r6_zero_releases: assert property (@(posedge clk) disable iff (rst)
    (pause_valid_i && pause_quanta_i == '0) |=> !tx_pause_o);

  a_r7_pause_no_veto: assert property (@(posedge clk) disable iff (rst)
    (pause_valid_i && !fe_veto_o && !fifo_afull_i && !ext_fe_dis_i && EXT_STAGES > 1) |=> !fe_veto_o);

  a_r8_busy_one_shot: assert property (@(posedge clk) disable iff (rst)
    busy_req_o |=> !busy_req_o);

  a_r9_cont_one_shot: assert property (@(posedge clk) disable iff (rst)
    cont_req_o |=> !cont_req_o);

  a_r9_never_both: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy_req_o, cont_req_o}));

  a_r10_shutter_gated: assert property (@(posedge clk) disable iff (rst)
    (fe_veto_o || tx_pause_o) |=> !shutter_o);
endmodule

bind rdo_throttle rdo_throttle_chk #(
  .QUANTA_W   (QUANTA_W),
  .EXT_STAGES (EXT_STAGES)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .fifo_afull_i   (fifo_afull_i),
  .fifo_alow_i    (fifo_alow_i),
  .pause_valid_i  (pause_valid_i),
  .pause_quanta_i (pause_quanta_i),
  .ext_fe_dis_i   (ext_fe_dis_i),
  .fe_veto_o      (fe_veto_o),
  .tx_pause_o     (tx_pause_o),
  .busy_req_o     (busy_req_o),
  .cont_req_o     (cont_req_o),
  .shutter_o      (shutter_o),
  .fifo_thr       (fifo_thr)
);

// File: tb/sim_rdo_throttle.sv
`timescale 1ns/1ps
module sim_rdo_throttle;
  localparam int QW = 16;
  localparam int EV_BUSY = 0;
  localparam int EV_CONT = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic afull = 0, alow = 0, pv = 0, ext = 0, shut = 0;
  logic [QW-1:0] quanta = '0;
  logic fe_veto, tx_pause, busy_req, cont_req, shut_o;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  rdo_throttle #(.QUANTA_W(QW), .BITS_PER_CYC(64), .EXT_STAGES(2)) u0 (
    .clk(clk), .rst(rst),
    .fifo_afull_i(afull), .fifo_alow_i(alow),
    .pause_valid_i(pv), .pause_quanta_i(quanta),
    .ext_fe_dis_i(ext), .shutter_i(shut),
    .fe_veto_o(fe_veto), .tx_pause_o(tx_pause),
    .busy_req_o(busy_req), .cont_req_o(cont_req), .shutter_o(shut_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected notifications (R8 busy, R9 continue)
  always @(negedge clk) begin
    if (!rst && (busy_req || cont_req)) begin
      checks++;
      if (busy_req && cont_req) begin
        errors++;
        $display("FAIL R9 both pulses actual=3 expected=1or2");
      end else if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected pulse actual=%0d expected=none", busy_req ? EV_BUSY : EV_CONT);
      end else begin
        int e;
        e = exp_q.pop_front();
        if ((busy_req ? EV_BUSY : EV_CONT) != e) begin
          errors++;
          $display("FAIL R8/R9 notify actual=%0d expected=%0d", busy_req ? EV_BUSY : EV_CONT, e);
        end
      end
    end
  end

  initial begin
    int cnt;
    step(3);
    chk("R1 veto in reset", fe_veto, 0);
    chk("R1 pause in reset", tx_pause, 0);
    chk("R1 shutter in reset", shut_o, 0);
    rst = 1'b0;
    step(1);
    chk("R1 busy after reset", busy_req, 0);
    chk("R1 cont after reset", cont_req, 0);

    shut = 1'b1;
    step(1);
    chk("R10 shutter passes", shut_o, 1);

    // FIFO hysteresis
    afull = 1; exp_q.push_back(EV_BUSY);
    step(1);
    chk("R2 veto on afull", fe_veto, 1);
    chk("R7 no tx pause from fifo", tx_pause, 0);
    step(1);
    chk("R10 shutter closed", shut_o, 0);
    afull = 0;
    step(3);
    chk("R3 veto held", fe_veto, 1);
    alow = 1; exp_q.push_back(EV_CONT);
    step(1);
    chk("R3 veto released on low", fe_veto, 0);
    alow = 0;
    step(2);
    chk("R10 shutter reopens", shut_o, 1);

    // both flags: afull wins
    afull = 1; alow = 1; exp_q.push_back(EV_BUSY);
    step(1);
    chk("R3 afull priority", fe_veto, 1);
    afull = 0; exp_q.push_back(EV_CONT);
    step(1);
    chk("R3 clear with low", fe_veto, 0);
    alow = 0;
    step(3);

    // external disable through 2-stage synchronizer
    ext = 1; exp_q.push_back(EV_BUSY);
    step(1);
    chk("R4 ext latency 1", fe_veto, 0);
    step(1);
    chk("R4 ext latency 2", fe_veto, 1);
    ext = 0; exp_q.push_back(EV_CONT);
    step(1);
    chk("R4 ext release latency 1", fe_veto, 1);
    step(1);
    chk("R4 ext released", fe_veto, 0);
    step(3);

    // pause of 3 quanta = 24 cycles
    pv = 1; quanta = 3; exp_q.push_back(EV_BUSY); exp_q.push_back(EV_CONT);
    step(1);
    pv = 0;
    chk("R7 pause no veto", fe_veto, 0);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      if (!tx_pause) break;
      cnt++;
      step(1);
    end
    chk("R5 pause length q3", cnt, 24);
    step(3);

    // zero-quanta request cuts pause short
    pv = 1; quanta = 10; exp_q.push_back(EV_BUSY); exp_q.push_back(EV_CONT);
    step(1);
    pv = 0;
    step(4);
    chk("R6 pause running", tx_pause, 1);
    pv = 1; quanta = 0;
    step(1);
    pv = 0;
    chk("R6 zero releases", tx_pause, 0);
    step(3);

    // second request restarts the count
    pv = 1; quanta = 2; exp_q.push_back(EV_BUSY); exp_q.push_back(EV_CONT);
    step(1);
    pv = 0;
    cnt = tx_pause ? 1 : 0;
    for (int i = 0; i < 3; i++) begin
      step(1);
      if (tx_pause) cnt++;
    end
    pv = 1; quanta = 2;
    step(1);
    pv = 0;
    if (tx_pause) cnt++;
    for (int i = 0; i < 100; i++) begin
      step(1);
      if (!tx_pause) break;
      cnt++;
    end
    chk("R6 reload length", cnt, 20);
    step(3);

    // overlapping causes: one busy/continue pair
    afull = 1; exp_q.push_back(EV_BUSY);
    step(2);
    ext = 1;
    step(3);
    afull = 0; alow = 1;
    step(2);
    chk("R9 veto kept by ext", fe_veto, 1);
    alow = 0; ext = 0; exp_q.push_back(EV_CONT);
    step(2);
    chk("R9 veto cleared", fe_veto, 0);
    step(4);
    chk("R9 all notifications seen", exp_q.size(), 0);
    chk("R10 shutter after overlap", shut_o, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule